// File: doc/BRIEF.md
# Handshaked Block Serial Streamer

The streamer copies a contiguous run of 32-bit words out of a data memory and sends them over a synchronous serial link to an external logger or signal processor. A slow timing strobe, issued one slow-clock period ahead of each processing pass, starts a transfer. The start address and the number of words come from configuration inputs. Once started, a transfer always runs to its end, even if the processing pass begins while words are still going out.

The link has three outputs and one input. The outputs are a serial clock, serial data and a frame marker. The input is an optional ready line from the receiver. The serial clock runs at a quarter or at half of the system clock. With a 20 MHz system clock that gives 5 MHz or 10 MHz. The clock either runs freely or is gated. When gated, it comes up three periods before the first frame and stops three periods after the last data bit. Words are sent most significant bit first, and the frame marker flags the first bit of each word, so 16-bit and 32-bit receivers can both align to it. When the handshake is enabled, the block waits between words until ready is high and keeps the clock toggling while it waits.

The memory is read through an asynchronous read port: `mem_rdata` must reflect `mem_addr` in the same cycle.

Top module: `blk_serial_streamer`

## Requirements
- R1: A one-cycle `trig` while idle, with `cfg_en` = 1 and `cfg_len` not zero, starts a transfer, and `busy` is high from the next clock cycle.
- R2: A transfer sends exactly `cfg_len` words, read from addresses `cfg_base`, `cfg_base`+1, and so on, modulo 2^AW. Each word is 32 bits, sent MSB first. `sframe` is high during the first bit of each word only.
- R3: With `cfg_fast` = 1 the serial clock period is 2 system clock cycles. With `cfg_fast` = 0 it is 4 cycles.
- R4: With `cfg_gate` = 1, `sclk` is low whenever `busy` is low. With `cfg_gate` = 0 and `cfg_en` = 1, `sclk` toggles continuously, including while idle.
- R5: In gated mode, exactly 3 rising edges of `sclk` precede the rising edge that samples the first frame bit. After the rising edge that samples the last data bit, exactly 3 more rising edges occur, and then `sclk` stays low.
- R6: With `cfg_hs` = 1, if `rdy` is low at a word boundary, the next word is held back until `rdy` is seen high, and `sclk` keeps toggling during the hold. With `cfg_hs` = 0, `rdy` has no effect.
- R7: `trig` has no effect while `busy` is high, while `cfg_en` = 0, or while `cfg_len` = 0.
- R8: `busy` stays high until the falling `sclk` edge that ends the tail. `sdata` and `sframe` are low whenever `busy` is low.
- R9: `sdata` and `sframe` change only at a falling edge of `sclk`, so they are stable at every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 20 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Slow timing strobe, one cycle wide |
| cfg_en | input | 1 | Interface enable |
| cfg_base | input | AW | Address of the first word |
| cfg_len | input | LW | Number of words per transfer |
| cfg_fast | input | 1 | 1: serial clock = clk/2, 0: clk/4 |
| cfg_gate | input | 1 | 1: serial clock gated when idle |
| cfg_hs | input | 1 | 1: honour the ready handshake |
| rdy | input | 1 | Receiver ready |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 32 | Memory read data for mem_addr |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| sframe | output | 1 | Frame marker, high on first bit of a word |
| busy | output | 1 | Transfer in progress |

## Verification
The main function is tried with the following transfers:
- a gated fast transfer, which separates word order, bit order and frame placement, and also measures the 3-period lead-in and tail;
- a gated slow transfer, which tells the two clock rates apart by period;
- a free-running transfer, which shows that idle clocking and data sending coexist;
- a block that starts near the top of the address space, which exposes address wrapping;
- a transfer with the handshake enabled and ready held low, which tells a held transfer from a stalled clock;
- a transfer with ready low but the handshake disabled, which shows that ready is ignored.

Triggers while disabled, with a zero length, or mid-transfer check that only legal strobes start a transfer.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int WORD_W = 32;
  localparam int PAD_PERIODS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_WAIT,
    ST_TAIL
  } ssx_state_e;
endpackage

// File: rtl/ssx_clkgen.sv
// Serial clock generator: toggles on every tick; tick every cycle (fast) or every other cycle (slow).
module ssx_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic sclk,
  output logic fall
);
  logic div_q, div_d;
  logic sclk_q, sclk_d;
  logic tick;

  always_comb begin
    tick   = run & (fast | div_q);
    div_d  = run & ~fast & ~div_q;
    sclk_d = run ? (sclk_q ^ tick) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      sclk_q <= sclk_d;
    end
  end

  assign fall = tick & sclk_q;
  assign sclk = sclk_q;
endmodule

// File: rtl/ssx_shifter.sv
// Output shift register: loads a word MSB first, shifts on command, clears between words.
module ssx_shifter #(
  parameter int WW = ssx_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          clear,
  input  logic [WW-1:0] word,
  output logic          sdata,
  output logic          sframe
);
  logic [WW-1:0] sh_q, sh_d;
  logic          sd_q, sd_d;
  logic          fr_q, fr_d;
  logic          upd;

  assign upd = load | shift | clear;

  always_comb begin
    sh_d = sh_q;
    sd_d = sd_q;
    fr_d = fr_q;
    if (load) begin
      sh_d = {word[WW-2:0], 1'b0};
      sd_d = word[WW-1];
      fr_d = 1'b1;
    end else if (shift) begin
      sh_d = {sh_q[WW-2:0], 1'b0};
      sd_d = sh_q[WW-1];
      fr_d = 1'b0;
    end else if (clear) begin
      sh_d = '0;
      sd_d = 1'b0;
      fr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sd_q <= 1'b0;
      fr_q <= 1'b0;
    end else if (upd) begin
      sh_q <= sh_d;
      sd_q <= sd_d;
      fr_q <= fr_d;
    end
  end

  assign sdata  = sd_q;
  assign sframe = fr_q;
endmodule

// File: rtl/ssx_seq.sv
// Transfer sequencer: lead-in, word shifting, handshake hold, tail.
module ssx_seq
  import ssx_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 8,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          cfg_en,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_fast,
  input  logic          cfg_hs,
  input  logic          fall,
  input  logic          rdy,
  output logic          busy,
  output logic          fast_q,
  output logic [AW-1:0] addr,
  output logic          load,
  output logic          shift,
  output logic          clear
);
  localparam int BW = $clog2(WW);
  localparam logic [BW-1:0] LAST_BIT = BW'(WW - 1);
  localparam logic [1:0] PAD_LAST = 2'(PAD_PERIODS - 1);

  ssx_state_e    state_q, state_d;
  logic [1:0]    pad_q, pad_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [LW-1:0] left_q, left_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          hs_q, hs_d;
  logic          fast_d;
  logic          start;

  assign start = trig & cfg_en & (cfg_len != '0);

  always_comb begin
    state_d = state_q;
    pad_d   = pad_q;
    bit_d   = bit_q;
    left_d  = left_q;
    addr_d  = addr_q;
    hs_d    = hs_q;
    fast_d  = fast_q;
    load    = 1'b0;
    shift   = 1'b0;
    clear   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LEAD;
          pad_d   = '0;
          addr_d  = cfg_base;
          left_d  = cfg_len;
          hs_d    = cfg_hs;
          fast_d  = cfg_fast;
        end
      end
      ST_LEAD: begin
        if (fall) begin
          if (pad_q == PAD_LAST) load = 1'b1;
          else pad_d = pad_q + 2'd1;
        end
      end
      ST_SHIFT: begin
        if (fall) begin
          if (bit_q != LAST_BIT) begin
            shift = 1'b1;
            bit_d = bit_q + 1'b1;
          end else if (left_q == '0) begin
            clear   = 1'b1;
            state_d = ST_TAIL;
            pad_d   = '0;
          end else if (hs_q && !rdy) begin
            clear   = 1'b1;
            state_d = ST_WAIT;
          end else begin
            load = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (fall && rdy) load = 1'b1;
      end
      ST_TAIL: begin
        if (fall) begin
          if (pad_q == PAD_LAST) state_d = ST_IDLE;
          else pad_d = pad_q + 2'd1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (load) begin
      state_d = ST_SHIFT;
      bit_d   = '0;
      addr_d  = addr_q + 1'b1;
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pad_q   <= '0;
      bit_q   <= '0;
      left_q  <= '0;
      addr_q  <= '0;
      hs_q    <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pad_q   <= pad_d;
      bit_q   <= bit_d;
      left_q  <= left_d;
      addr_q  <= addr_d;
      hs_q    <= hs_d;
      fast_q  <= fast_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign addr = addr_q;
endmodule

// File: rtl/blk_serial_streamer.sv
module blk_serial_streamer
  import ssx_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              cfg_en,
  input  logic [AW-1:0]     cfg_base,
  input  logic [LW-1:0]     cfg_len,
  input  logic              cfg_fast,
  input  logic              cfg_gate,
  input  logic              cfg_hs,
  input  logic              rdy,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              sclk,
  output logic              sdata,
  output logic              sframe,
  output logic              busy
);
  logic rst_s1_q, rst_s2_q;
  logic run, fast_eff, fast_q, fall;
  logic load, shift, clear;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign fast_eff = busy ? fast_q : cfg_fast;
  assign run      = busy | (cfg_en & ~cfg_gate);

  ssx_clkgen u_clk (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .run   (run),
    .fast  (fast_eff),
    .sclk  (sclk),
    .fall  (fall)
  );

  ssx_seq #(.AW(AW), .LW(LW), .WW(WORD_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .trig     (trig),
    .cfg_en   (cfg_en),
    .cfg_base (cfg_base),
    .cfg_len  (cfg_len),
    .cfg_fast (cfg_fast),
    .cfg_hs   (cfg_hs),
    .fall     (fall),
    .rdy      (rdy),
    .busy     (busy),
    .fast_q   (fast_q),
    .addr     (mem_addr),
    .load     (load),
    .shift    (shift),
    .clear    (clear)
  );

  ssx_shifter #(.WW(WORD_W)) u_sh (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .load   (load),
    .shift  (shift),
    .clear  (clear),
    .word   (mem_rdata),
    .sdata  (sdata),
    .sframe (sframe)
  );
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker #(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          cfg_en,
  input logic [LW-1:0] cfg_len,
  input logic          cfg_gate,
  input logic          sclk,
  input logic          sdata,
  input logic          sframe,
  input logic          busy
);
  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && cfg_en && cfg_len != '0) |=> busy);

  p_frame_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && $past(sframe)) |-> !sframe);

  p_gated_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && cfg_gate && $past(cfg_gate)) |-> !sclk);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sdata && !sframe));

  p_data_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata != $past(sdata) || sframe != $past(sframe)) |-> ($past(sclk) && !sclk));
endmodule

bind blk_serial_streamer ssx_checker #(.LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig     (trig),
  .cfg_en   (cfg_en),
  .cfg_len  (cfg_len),
  .cfg_gate (cfg_gate),
  .sclk     (sclk),
  .sdata    (sdata),
  .sframe   (sframe),
  .busy     (busy)
);

// File: tb/blk_serial_streamer_test.sv
module blk_serial_streamer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0, cfg_en = 1'b0, cfg_fast = 1'b0, cfg_gate = 1'b1, cfg_hs = 1'b0, rdy = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_rdata;
  logic          sclk, sdata, sframe, busy;
  logic [31:0]   mem [256];

  int checks = 0, fails = 0;
  int ncyc = 0, rises = 0, last_rise = 0, per = 0;
  int frame_rise = 0, last_bit_rise = 0, nbits = 0, rx_n = 0;
  logic [31:0] acc;
  logic [31:0] rx [16];
  logic        sclk_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  blk_serial_streamer #(.AW(AW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_en(cfg_en), .cfg_base(cfg_base),
    .cfg_len(cfg_len), .cfg_fast(cfg_fast), .cfg_gate(cfg_gate), .cfg_hs(cfg_hs),
    .rdy(rdy), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .sclk(sclk),
    .sdata(sdata), .sframe(sframe), .busy(busy)
  );

  // Receiver model: samples on sclk rises seen at falling clk edges.
  always @(negedge clk) begin
    ncyc++;
    if (sclk && !sclk_prev) begin
      rises++;
      per = ncyc - last_rise;
      last_rise = ncyc;
      if (sframe) begin
        acc = {31'b0, sdata};
        nbits = 1;
        if (frame_rise == 0) frame_rise = rises;
      end else if (nbits > 0 && nbits < 32) begin
        acc = {acc[30:0], sdata};
        nbits++;
      end
      if (nbits == 32) begin
        if (rx_n < 16) rx[rx_n] = acc;
        rx_n++;
        nbits = 0;
        last_bit_rise = rises;
      end
    end
    sclk_prev = sclk;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_rx();
    @(posedge clk);
    rises = 0; frame_rise = 0; last_bit_rise = 0; nbits = 0; rx_n = 0;
    #1;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 20000) begin step(1); guard++; end
  endtask

  task automatic setup(input int base, input int len, input bit fast, input bit gate, input bit hs);
    @(negedge clk);
    cfg_en = 1'b1; cfg_base = AW'(base); cfg_len = LW'(len);
    cfg_fast = fast; cfg_gate = gate; cfg_hs = hs;
  endtask

  task automatic check_words(input int base, input int len, input string tag);
    check(rx_n == len, {tag, " word count"}, rx_n, len);
    for (int i = 0; i < len && i < 16; i++)
      check(rx[i] == mem[(base + i) % 256], {tag, " word data"}, rx[i], mem[(base + i) % 256]);
  endtask

  task automatic t_reset();
    step(1);
    check(!sclk && !sdata && !sframe && !busy, "R8 reset outputs", {sclk, sdata, sframe, busy}, 0);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_gated_fast();
    setup(5, 3, 1'b1, 1'b1, 1'b0);
    clear_rx();
    step(6);
    check(rises == 0, "R4 gated idle clock", rises, 0);
    pulse_trig();
    #1;
    check(busy == 1'b1, "R1 busy after trigger", busy, 1);
    wait_idle();
    check_words(5, 3, "R2 gated fast");
    check(frame_rise == 4, "R5 lead-in rises", frame_rise, 4);
    check(rises - last_bit_rise == 3, "R5 tail rises", rises - last_bit_rise, 3);
    check(per == 2, "R3 fast period", per, 2);
    check(!sclk && !sdata && !sframe, "R8 quiet after tail", {sclk, sdata, sframe}, 0);
  endtask

  task automatic t_gated_slow();
    setup(40, 2, 1'b0, 1'b1, 1'b0);
    clear_rx();
    pulse_trig();
    wait_idle();
    check_words(40, 2, "R2 gated slow");
    check(per == 4, "R3 slow period", per, 4);
    check(frame_rise == 4, "R5 slow lead-in", frame_rise, 4);
  endtask

  task automatic t_free_run();
    setup(100, 2, 1'b1, 1'b0, 1'b0);
    step(4);
    clear_rx();
    step(40);
    check(rises == 20, "R4 free-running idle clock", rises, 20);
    clear_rx();
    pulse_trig();
    wait_idle();
    check_words(100, 2, "R2 free running");
    clear_rx();
    step(10);
    check(rises == 5 && !busy, "R4 clock continues after transfer", rises, 5);
    setup(100, 2, 1'b1, 1'b1, 1'b0);
    step(4);
  endtask

  task automatic t_wrap();
    setup(254, 4, 1'b1, 1'b1, 1'b0);
    clear_rx();
    pulse_trig();
    wait_idle();
    check_words(254, 4, "R2 address wrap");
  endtask

  task automatic t_handshake();
    int guard = 0;
    int r0;
    rdy = 1'b0;
    setup(20, 3, 1'b1, 1'b1, 1'b1);
    clear_rx();
    pulse_trig();
    while (rx_n < 1 && guard < 2000) begin step(1); guard++; end
    step(4);
    r0 = rises;
    step(60);
    check(rx_n == 1, "R6 held while not ready", rx_n, 1);
    check(busy == 1'b1, "R6 busy during hold", busy, 1);
    check(rises - r0 == 30, "R6 clock runs during hold", rises - r0, 30);
    check(!sdata && !sframe, "R6 lines quiet during hold", {sdata, sframe}, 0);
    @(negedge clk); rdy = 1'b1;
    wait_idle();
    check_words(20, 3, "R6 after ready");
  endtask

  task automatic t_no_hs();
    rdy = 1'b0;
    setup(60, 2, 1'b0, 1'b1, 1'b0);
    clear_rx();
    pulse_trig();
    wait_idle();
    check_words(60, 2, "R6 ready ignored without handshake");
    rdy = 1'b1;
  endtask

  task automatic t_ignored();
    setup(0, 2, 1'b1, 1'b1, 1'b0);
    @(negedge clk); cfg_en = 1'b0;
    clear_rx();
    pulse_trig();
    step(20);
    check(!busy && rises == 0, "R7 trigger ignored while disabled", {busy, rises[7:0]}, 0);
    setup(0, 0, 1'b1, 1'b1, 1'b0);
    clear_rx();
    pulse_trig();
    step(20);
    check(!busy && rises == 0, "R7 trigger ignored with zero length", {busy, rises[7:0]}, 0);
    setup(70, 2, 1'b1, 1'b1, 1'b0);
    clear_rx();
    pulse_trig();
    step(30);
    pulse_trig();
    wait_idle();
    check_words(70, 2, "R7 retrigger while busy");
    step(20);
    check(!busy && rx_n == 2, "R7 no second transfer", rx_n, 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'hA5A50F0F;
    rdy = 1'b1;
    t_reset();
    t_gated_fast();
    t_gated_slow();
    t_free_run();
    t_wrap();
    t_handshake();
    t_no_hs();
    t_ignored();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule